// File: doc/BRIEF.md
# Three-Bank Programmable Clock Divider

This block turns one fast source clock into three banks of divided clocks, each bank with two identical outputs. Banks A and B each pick a divide of two or four, and bank C picks a divide of four or six. A shared power-down input doubles every ratio. A two-bit enable code chooses which banks run, and the banks that do not run are held low. A select input feeds the dividers either from the PLL clock or straight from the reference clock. Both source clocks are ordinary data inputs. They are sampled on the block clock `clk`, and every rising edge of the selected source counts as one divider tick.

All banks restart together from one common phase. Divide selects and power-down are latched only at a common boundary, which is a tick where every bank's internal divider is low and about to rise. Every bank has a gate state machine with two states, GATE_HELD and GATE_PASS. The gate is re-evaluated only on the tick where that bank's internal divider rises. HELD moves to PASS when the bank is enabled, and PASS moves to HELD when it is disabled. A sequencer state machine has two states. It leaves SEQ_WAIT for SEQ_RUN on the first tick after the master reset releases, and that tick is the first restart. In SEQ_RUN, a restart happens on every tick where all banks report the end of their period. The active-low master reset `mr_n` clears everything asynchronously.

Top module: `tri_bank_clkdiv`

## Requirements
- R1: With power-down low, bank A divides the tick rate by 2 when `a_sel`=0 and by 4 when `a_sel`=1.
- R2: With power-down low, bank B divides the tick rate by 2 when `b_sel`=0 and by 4 when `b_sel`=1.
- R3: With power-down low, bank C divides the tick rate by 4 when `c_sel`=0 and by 6 when `c_sel`=1.
- R4: With `pwr_dn`=1, every bank's ratio doubles: A and B become 4 or 8, and C becomes 8 or 12.
- R5: The enable code `en_code` maps to running banks as follows: 2'b00 runs A only, 2'b01 runs C only, 2'b10 runs A and C, and 2'b11 runs all three. A bank that is not running stays low.
- R6: While `mr_n` is low, every output is low. After release, the first tick raises every enabled bank in the same cycle.
- R7: A tick is a rising edge of `pll_clk` when `pll_sel`=1, or of `ref_clk` when `pll_sel`=0. Outputs change only in the cycle after a tick.
- R8: Every output has a 50% duty cycle, measured in ticks, for all ratios including 6 and 12.
- R9: A change of `en_code` takes effect only at that bank's own rising boundary, so every high pulse has the full half-period length.
- R10: Changes to `a_sel`, `b_sel`, `c_sel` and `pwr_dn` are applied only at a common boundary. Every high pulse has either the old or the new full half-period length.
- R11: Whenever bank C's ratio is a multiple of bank A's (or B's) ratio, each rising edge of C coincides with a rising edge of that bank.
- R12: The two outputs of a bank are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples the source clocks |
| mr_n | input | 1 | Active-low asynchronous master reset |
| pll_clk | input | 1 | PLL-derived source clock |
| ref_clk | input | 1 | Reference source clock |
| pll_sel | input | 1 | 1 selects `pll_clk` as the source, 0 selects `ref_clk` |
| a_sel | input | 1 | Bank A ratio select |
| b_sel | input | 1 | Bank B ratio select |
| c_sel | input | 1 | Bank C ratio select |
| pwr_dn | input | 1 | Doubles every ratio when 1 |
| en_code | input | 2 | Bank enable code |
| qa | output | 2 | Bank A outputs |
| qb | output | 2 | Bank B outputs |
| qc | output | 2 | Bank C outputs |

## Verification
The hardest condition to reach from the ports is a control change that lands in the middle of a bank's high phase. A wrong design would then cut a pulse short or stretch it. To reach it, the stimulus changes the enable code and bank C's ratio select at offsets that drift against every period. Meanwhile a monitor measures every high pulse and requires a complete half-period length. Alignment is probed by waiting for a rising edge of C and checking that the other banks rise in the same cycle whenever their ratios divide C's.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    typedef enum logic { GATE_HELD = 1'b0, GATE_PASS = 1'b1 } gate_state_t;
    typedef enum logic { SEQ_WAIT = 1'b0, SEQ_RUN = 1'b1 } seq_state_t;
    localparam int NUM_BANKS = 3;
endpackage

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int R_LO = 2,
    parameter int R_HI = 4
) (
    input  logic clk,
    input  logic mr_n,
    input  logic tick,
    input  logic restart,
    input  logic sel,
    input  logic pd,
    input  logic en,
    output logic out,
    output logic at_end
);
    localparam int H_LO = R_LO / 2;
    localparam int H_HI = R_HI / 2;
    localparam int HMAX = 2 * H_HI;
    localparam int HW   = $clog2(HMAX + 1);

    logic [HW-1:0] half, half_m1, h_q, h_n;
    logic          q_q, q_n, last;
    gate_state_t   g_q, g_n;

    always_comb begin
        half    = sel ? HW'(H_HI) : HW'(H_LO);
        if (pd) half = half << 1;
        half_m1 = half - HW'(1);
        last    = (h_q == half_m1);
        at_end  = !q_q && last;
    end

    always_comb begin
        h_n = h_q;
        q_n = q_q;
        g_n = g_q;
        if (tick) begin
            if (restart) begin
                h_n = '0;
                q_n = 1'b1;
                g_n = en ? GATE_PASS : GATE_HELD;
            end else if (last) begin
                h_n = '0;
                q_n = !q_q;
                if (!q_q) begin
                    unique case (g_q)
                        GATE_HELD: g_n = en ? GATE_PASS : GATE_HELD;
                        GATE_PASS: g_n = en ? GATE_PASS : GATE_HELD;
                    endcase
                end
            end else begin
                h_n = h_q + HW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge mr_n) begin
        if (!mr_n) begin
            h_q <= '0;
            q_q <= 1'b0;
            g_q <= GATE_HELD;
        end else begin
            h_q <= h_n;
            q_q <= q_n;
            g_q <= g_n;
        end
    end

    always_comb out = q_q && (g_q == GATE_PASS);

    assert_half_bound_R8: assert property (@(posedge clk) disable iff (!mr_n)
        h_q <= half_m1);
    assert_gate_when_low_R9: assert property (@(posedge clk) disable iff (!mr_n)
        !$stable(g_q) |-> !$past(q_q));
    assert_edge_on_tick_R7: assert property (@(posedge clk) disable iff (!mr_n)
        !$stable(q_q) |-> $past(tick));
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
    import clkdiv_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic          clk,
    input  logic          mr_n,
    input  logic          pll_clk,
    input  logic          ref_clk,
    input  logic          pll_sel,
    input  logic [NB-1:0] sel_in,
    input  logic          pd_in,
    input  logic [NB-1:0] bank_end,
    output logic          tick,
    output logic          restart,
    output logic [NB-1:0] cfg_sel,
    output logic          cfg_pd
);
    logic       src, src_q;
    seq_state_t st_q, st_n;

    always_comb begin
        src  = pll_sel ? pll_clk : ref_clk;
        tick = src && !src_q;
    end

    always_comb begin
        st_n    = st_q;
        restart = 1'b0;
        unique case (st_q)
            SEQ_WAIT: if (tick) begin
                restart = 1'b1;
                st_n    = SEQ_RUN;
            end
            SEQ_RUN: restart = tick && (&bank_end);
        endcase
    end

    always_ff @(posedge clk or negedge mr_n) begin
        if (!mr_n) begin
            st_q    <= SEQ_WAIT;
            src_q   <= 1'b0;
            cfg_sel <= '0;
            cfg_pd  <= 1'b0;
        end else begin
            st_q  <= st_n;
            src_q <= src;
            if (restart) begin
                cfg_sel <= sel_in;
                cfg_pd  <= pd_in;
            end
        end
    end

    assert_cfg_at_boundary_R10: assert property (@(posedge clk) disable iff (!mr_n)
        !$stable({cfg_sel, cfg_pd}) |-> $past(restart));
endmodule

// File: rtl/tri_bank_clkdiv.sv
module tri_bank_clkdiv
    import clkdiv_pkg::*;
#(
    parameter int A_LO = 2,
    parameter int A_HI = 4,
    parameter int B_LO = 2,
    parameter int B_HI = 4,
    parameter int C_LO = 4,
    parameter int C_HI = 6,
    parameter int OUTS = 2
) (
    input  logic            clk,
    input  logic            mr_n,
    input  logic            pll_clk,
    input  logic            ref_clk,
    input  logic            pll_sel,
    input  logic            a_sel,
    input  logic            b_sel,
    input  logic            c_sel,
    input  logic            pwr_dn,
    input  logic [1:0]      en_code,
    output logic [OUTS-1:0] qa,
    output logic [OUTS-1:0] qb,
    output logic [OUTS-1:0] qc
);
    localparam int NB = NUM_BANKS;
    localparam int LO_TAB [NB] = '{A_LO, B_LO, C_LO};
    localparam int HI_TAB [NB] = '{A_HI, B_HI, C_HI};

    logic          tick, restart, cfg_pd;
    logic [NB-1:0] cfg_sel, bank_end, bank_out, en_vec;

    always_comb begin
        en_vec[0] = (en_code != 2'b01);
        en_vec[1] = (en_code == 2'b11);
        en_vec[2] = (en_code != 2'b00);
    end

    clkdiv_seq #(.NB(NB)) u_seq (
        .clk      (clk),
        .mr_n     (mr_n),
        .pll_clk  (pll_clk),
        .ref_clk  (ref_clk),
        .pll_sel  (pll_sel),
        .sel_in   ({c_sel, b_sel, a_sel}),
        .pd_in    (pwr_dn),
        .bank_end (bank_end),
        .tick     (tick),
        .restart  (restart),
        .cfg_sel  (cfg_sel),
        .cfg_pd   (cfg_pd)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        clkdiv_bank #(.R_LO(LO_TAB[i]), .R_HI(HI_TAB[i])) u_bank (
            .clk     (clk),
            .mr_n    (mr_n),
            .tick    (tick),
            .restart (restart),
            .sel     (cfg_sel[i]),
            .pd      (cfg_pd),
            .en      (en_vec[i]),
            .out     (bank_out[i]),
            .at_end  (bank_end[i])
        );
    end

    always_comb begin
        qa = {OUTS{bank_out[0]}};
        qb = {OUTS{bank_out[1]}};
        qc = {OUTS{bank_out[2]}};
    end

    assert_reset_low_R6: assert property (@(posedge clk)
        !mr_n |-> (qa == '0 && qb == '0 && qc == '0));
endmodule

// File: tb/sim_tri_bank_clkdiv.sv
module sim_tri_bank_clkdiv;
    logic clk = 1'b0;
    logic mr_n = 1'b0;
    logic pll_clk = 1'b0, ref_clk = 1'b0, rph = 1'b0;
    logic pll_sel = 1'b1, a_sel = 1'b0, b_sel = 1'b0, c_sel = 1'b0, pwr_dn = 1'b0;
    logic [1:0] en_code = 2'b11;
    logic [1:0] qa, qb, qc;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;
    always @(negedge clk) pll_clk <= ~pll_clk;
    always @(negedge clk) begin
        rph <= ~rph;
        if (rph) ref_clk <= ~ref_clk;
    end

    tri_bank_clkdiv u0 (
        .clk(clk), .mr_n(mr_n), .pll_clk(pll_clk), .ref_clk(ref_clk),
        .pll_sel(pll_sel), .a_sel(a_sel), .b_sel(b_sel), .c_sel(c_sel),
        .pwr_dn(pwr_dn), .en_code(en_code), .qa(qa), .qb(qb), .qc(qc)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic bit_of(input int b);
        case (b)
            0: return qa[0];
            1: return qb[0];
            default: return qc[0];
        endcase
    endfunction

    // pulse monitor for R9 / R10
    bit mon_on = 0;
    int ok0 [3];
    int ok1 [3];
    int run [3];
    bit started [3];
    logic prv [3];
    always @(negedge clk) begin
        for (int b = 0; b < 3; b++) begin
            logic cur;
            cur = bit_of(b);
            if (!mon_on) begin
                started[b] = 0;
                run[b] = 0;
            end else if (cur && !prv[b]) begin
                started[b] = 1;
                run[b] = 1;
            end else if (cur) begin
                run[b]++;
            end else if (prv[b] && started[b]) begin
                check(run[b] == ok0[b] || run[b] == ok1[b], "R9 R10 full high pulse", run[b], ok0[b]);
            end
            prv[b] = cur;
        end
    end

    task automatic measure(input int b, output int hi, output int lo);
        int guard;
        logic p;
        hi = 0; lo = 0; guard = 0;
        @(negedge clk); p = bit_of(b);
        while (!(bit_of(b) && !p) && guard < 400) begin
            p = bit_of(b); @(negedge clk); guard++;
        end
        while (bit_of(b) && guard < 800) begin
            check(qa[0] == qa[1] && qb[0] == qb[1] && qc[0] == qc[1], "R12 pair equal", int'(qa), int'({qa[0], qa[0]}));
            hi++; @(negedge clk); guard++;
        end
        while (!bit_of(b) && guard < 1200) begin
            lo++; @(negedge clk); guard++;
        end
    endtask

    task automatic align_check(input int ra, input int rb, input int rc);
        logic pa, pb, pc;
        int guard;
        guard = 0;
        @(negedge clk);
        pa = qa[0]; pb = qb[0]; pc = qc[0];
        @(negedge clk);
        while (!(qc[0] && !pc) && guard < 400) begin
            pa = qa[0]; pb = qb[0]; pc = qc[0]; @(negedge clk); guard++;
        end
        if (rc % ra == 0) check(qa[0] && !pa, "R11 A rises with C", int'(qa[0]), 1);
        if (rc % rb == 0) check(qb[0] && !pb, "R11 B rises with C", int'(qb[0]), 1);
    endtask

    initial begin
        #2000000;
        miscompares++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int hi, lo;
        // reset state
        repeat (5) @(negedge clk);
        check(qa == 0 && qb == 0 && qc == 0, "R6 outputs low in reset", int'({qa, qb, qc}), 0);
        mr_n = 1'b1;
        repeat (3) @(negedge clk);

        // sweep: source, power-down, all three selects (R1 R2 R3 R4 R7 R8 R11)
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 2; p++) begin
                for (int k = 0; k < 8; k++) begin
                    int gap, ra, rb, rc;
                    pll_sel = s[0]; pwr_dn = p[0];
                    a_sel = k[0]; b_sel = k[1]; c_sel = k[2];
                    gap = s ? 2 : 4;
                    ra = (k[0] ? 4 : 2) << p;
                    rb = (k[1] ? 4 : 2) << p;
                    rc = (k[2] ? 6 : 4) << p;
                    repeat (250) @(negedge clk);
                    measure(0, hi, lo);
                    check(hi == ra / 2 * gap, "R1 R4 R7 bank A high", hi, ra / 2 * gap);
                    check(lo == ra / 2 * gap, "R1 R8 bank A low", lo, ra / 2 * gap);
                    measure(1, hi, lo);
                    check(hi == rb / 2 * gap, "R2 R4 R7 bank B high", hi, rb / 2 * gap);
                    check(lo == rb / 2 * gap, "R2 R8 bank B low", lo, rb / 2 * gap);
                    measure(2, hi, lo);
                    check(hi == rc / 2 * gap, "R3 R4 R7 bank C high", hi, rc / 2 * gap);
                    check(lo == rc / 2 * gap, "R3 R8 bank C low", lo, rc / 2 * gap);
                    align_check(ra, rb, rc);
                end
            end
        end

        // enable code mapping (R5)
        pll_sel = 1; pwr_dn = 0; a_sel = 0; b_sel = 0; c_sel = 0;
        for (int e = 0; e < 4; e++) begin
            int cnt [3];
            logic pr [3];
            bit expv [3];
            en_code = e[1:0];
            expv[0] = (e != 1); expv[1] = (e == 3); expv[2] = (e != 0);
            repeat (150) @(negedge clk);
            for (int b = 0; b < 3; b++) begin cnt[b] = 0; pr[b] = bit_of(b); end
            repeat (120) begin
                @(negedge clk);
                for (int b = 0; b < 3; b++) begin
                    if (bit_of(b) && !pr[b]) cnt[b]++;
                    pr[b] = bit_of(b);
                end
            end
            for (int b = 0; b < 3; b++)
                check((cnt[b] > 0) == expv[b], "R5 bank runs per code", cnt[b], int'(expv[b]));
        end

        // enable toggling at drifting offsets (R9)
        ok0 = '{2, 2, 4}; ok1 = '{2, 2, 4};
        mon_on = 1;
        for (int k = 0; k < 40; k++) begin
            en_code = 2'(k % 4);
            repeat (k % 7 + 3) @(negedge clk);
        end
        en_code = 2'b11;
        repeat (60) @(negedge clk);
        mon_on = 0;

        // config changes at drifting offsets (R10)
        repeat (3) @(negedge clk);
        ok0 = '{2, 2, 4}; ok1 = '{2, 2, 6};
        mon_on = 1;
        for (int k = 0; k < 30; k++) begin
            c_sel = k[0];
            repeat (k % 9 + 5) @(negedge clk);
        end
        c_sel = 0;
        repeat (80) @(negedge clk);
        mon_on = 0;

        // reset mid-run and common restart (R6)
        @(negedge clk); mr_n = 0;
        repeat (3) @(negedge clk);
        check(qa == 0 && qb == 0 && qc == 0, "R6 outputs low during reset", int'({qa, qb, qc}), 0);
        @(negedge clk); mr_n = 1;
        begin
            int guard;
            guard = 0;
            while (qa[0] == 0 && qb[0] == 0 && qc[0] == 0 && guard < 20) begin
                @(negedge clk); guard++;
            end
            check(qa[0] && qb[0] && qc[0], "R6 common first rise", int'({qa[0], qb[0], qc[0]}), 7);
        end
        repeat (20) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule